// File: doc/BRIEF.md
# Timestamped Run-Length Sample Packer

This block compresses a stream of 16-bit logic samples into short records for a sample memory. A sample arrives with a one-clock tick strobe and the current value of a free-running 16-bit tick counter. While the sampled levels stay the same, the block stores nothing.

When a level change arrives, the block opens a cluster of eight memory words. The first word is the tick counter value at the opening tick. The other seven words are the samples of that tick and of the six ticks after it, stored whether or not they change. If the input stays quiet for a long time, the block forces a cluster anyway. This bounds the distance between two cluster timestamps, so a reader can always tell where the counter rolled over.

Words leave on a write strobe together with a linear write address. The high part of the address names a memory row and the low part names the word within that row. The block also keeps a running count of stored samples and a sticky flag that records the address wrapping back to zero.

Top module: `ts_rle_packer`

## Requirements
- R1: After reset, `wr_en` is 0, `wr_addr` is 0, `sample_count` is 0 and `mem_wrapped` is 0.
- R2: The first tick after reset always opens a cluster. The first word of every cluster is the timestamp word, equal to `stamp_in` at the opening tick.
- R3: A cluster is eight words long. After the timestamp come seven sample words: the sample of the opening tick, then the samples of the next six ticks in order, stored even when they repeat.
- R4: When the block is not filling a cluster, a tick whose sample equals the last stored sample writes nothing and leaves `sample_count` unchanged, unless R6 applies.
- R5: A change that arrives while a cluster is filling is only stored in that cluster. After the cluster ends, a new one opens on the first tick whose sample differs from the last sample written.
- R6: If no cluster has opened for FORCE_TICKS ticks (default 65536), the tick that lies FORCE_TICKS ticks after the last opening tick opens a cluster even without a change. FORCE_TICKS must be at least 8.
- R7: Words are written at consecutive addresses starting from 0. `wr_addr` is ROW_W+EVT_W bits wide (default 15+9=24). The upper ROW_W bits hold the row and the lower EVT_W bits hold the word within the row, so a row holds 64 clusters (448 samples).
- R8: After the word at the last address of the last row, the address returns to row 0, word 0, and `mem_wrapped` goes to 1 and stays at 1 until reset.
- R9: `sample_count` rises by one for every sample word written. Timestamp words do not count.
- R10: Ticks are at least two clocks apart. Each word is presented on `wr_en`/`wr_data`/`wr_addr` for one clock. A timestamp word or a later sample word appears in the clock after its tick is sampled. The first sample of a cluster appears in the clock after its timestamp word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe, one clock wide |
| sample_in | input | 16 | Sampled channel levels |
| stamp_in | input | 16 | Free-running tick counter value |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | 16 | Word to write (timestamp or sample) |
| wr_addr | output | ROW_W+EVT_W | Write address: row in the high bits, word in row in the low bits |
| mem_wrapped | output | 1 | Sticky flag: the address has returned to 0 |
| sample_count | output | CNT_W | Number of sample words stored |

## Verification
Some properties are checked by assertions on every cycle:
- the address steps by exactly one per written word;
- the wrap flag never drops;
- the sample count moves in step with sample words;
- a timestamp word is always followed at once by a sample word;
- the fill position stays inside the cluster;
- the quiet-tick counter stays inside the forcing window;
- ticks respect their spacing.

Other behaviour only the bench's scenarios can show. This covers:
- whether a cluster opens on exactly the right tick, both for changes and for forced clusters;
- that repeated levels produce no writes;
- that stored data carries the right timestamp and samples in order;
- how addresses cross row boundaries and wrap.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_CLUSTER_SAMPLES = 7;

  typedef enum logic {
    SP_WORD_STAMP,
    SP_WORD_SAMPLE
  } sp_word_e;

  // Fill position after one more sample; 0 means the cluster is complete.
  function automatic logic [2:0] sp_fill_next(input logic [2:0] pos);
    return (pos == 3'(SP_CLUSTER_SAMPLES - 1)) ? 3'd0 : pos + 3'd1;
  endfunction
endpackage

// File: rtl/sp_change_watch.sv
module sp_change_watch #(
  parameter int WORD_W      = 16,
  parameter int FORCE_TICKS = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] sample,
  input  logic              busy,
  output logic              open_req
);
  localparam int GW = $clog2(FORCE_TICKS + 1);

  logic              primed;
  logic [WORD_W-1:0] last_kept;
  logic [GW-1:0]     gap;
  logic              differs;
  logic              due;

  function automatic logic gap_due(input logic [GW-1:0] g);
    return g >= GW'(FORCE_TICKS - 1);
  endfunction

  assign differs  = !primed || (sample != last_kept);
  assign due      = gap_due(gap);
  assign open_req = tick && !busy && (differs || due);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      last_kept <= '0;
      gap       <= '0;
    end else if (tick) begin
      if (open_req) begin
        gap    <= '0;
        primed <= 1'b1;
      end else if (gap < GW'(FORCE_TICKS)) begin
        gap <= gap + 1'b1;
      end
      if (open_req || busy) last_kept <= sample;
    end
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (gap <= GW'(FORCE_TICKS - 1))); // R6
endmodule

// File: rtl/sp_cluster_fill.sv
module sp_cluster_fill
  import sp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              open_req,
  input  logic [WORD_W-1:0] sample,
  input  logic [WORD_W-1:0] stamp,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output sp_word_e          wr_kind,
  output logic              busy
);
  logic [2:0]        fill;
  logic              pend_v;
  logic [WORD_W-1:0] pend;

  assign busy = (fill != 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill    <= 3'd0;
      pend_v  <= 1'b0;
      pend    <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_kind <= SP_WORD_STAMP;
    end else if (open_req) begin
      wr_en   <= 1'b1;
      wr_data <= stamp;
      wr_kind <= SP_WORD_STAMP;
      pend_v  <= 1'b1;
      pend    <= sample;
      fill    <= 3'd1;
    end else if (pend_v) begin
      wr_en   <= 1'b1;
      wr_data <= pend;
      wr_kind <= SP_WORD_SAMPLE;
      pend_v  <= 1'b0;
    end else if (tick && busy) begin
      wr_en   <= 1'b1;
      wr_data <= sample;
      wr_kind <= SP_WORD_SAMPLE;
      fill    <= sp_fill_next(fill);
    end else begin
      wr_en   <= 1'b0;
    end
  end

  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 3'(SP_CLUSTER_SAMPLES - 1)); // R3
  AST_STAMP_THEN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == SP_WORD_STAMP) |=> (wr_en && wr_kind == SP_WORD_SAMPLE)); // R2
endmodule

// File: rtl/sp_addr_track.sv
module sp_addr_track #(
  parameter int ROW_W = 15,
  parameter int EVT_W = 9,
  parameter int CNT_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   is_sample,
  output logic [ROW_W+EVT_W-1:0] addr,
  output logic                   wrapped,
  output logic [CNT_W-1:0]       sample_count
);
  localparam int AW = ROW_W + EVT_W;

  logic [AW-1:0] cur;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic addr_last(input logic [AW-1:0] a);
    return &a;
  endfunction

  assign addr = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur          <= '0;
      wrapped      <= 1'b0;
      sample_count <= '0;
    end else if (wr_en) begin
      cur <= addr_step(cur);
      if (addr_last(cur)) wrapped <= 1'b1;
      if (is_sample) sample_count <= sample_count + 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr == $past(addr) + AW'(1))); // R7
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_sample) |=> (sample_count == $past(sample_count) + 1'b1)); // R9
endmodule

// File: rtl/ts_rle_packer.sv
module ts_rle_packer
  import sp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ROW_W       = 15,
  parameter int EVT_W       = 9,
  parameter int FORCE_TICKS = 65536,
  parameter int CNT_W       = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [WORD_W-1:0]      sample_in,
  input  logic [WORD_W-1:0]      stamp_in,
  output logic                   wr_en,
  output logic [WORD_W-1:0]      wr_data,
  output logic [ROW_W+EVT_W-1:0] wr_addr,
  output logic                   mem_wrapped,
  output logic [CNT_W-1:0]       sample_count
);
  logic     open_req;
  logic     busy;
  sp_word_e wr_kind;
  logic     is_sample;

  assign is_sample = (wr_kind == SP_WORD_SAMPLE);

  sp_change_watch #(.WORD_W(WORD_W), .FORCE_TICKS(FORCE_TICKS)) u_watch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample_in),
    .busy(busy), .open_req(open_req)
  );

  sp_cluster_fill #(.WORD_W(WORD_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .tick(tick), .open_req(open_req),
    .sample(sample_in), .stamp(stamp_in), .wr_en(wr_en),
    .wr_data(wr_data), .wr_kind(wr_kind), .busy(busy)
  );

  sp_addr_track #(.ROW_W(ROW_W), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_sample(is_sample),
    .addr(wr_addr), .wrapped(mem_wrapped), .sample_count(sample_count)
  );

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10
endmodule

// File: tb/ts_rle_packer_bench.sv
`timescale 1ns/1ps
module ts_rle_packer_bench;
  localparam int WORD_W = 16;
  localparam int ROW_W  = 2;
  localparam int EVT_W  = 9;
  localparam int FORCE  = 40;
  localparam int CNT_W  = 24;
  localparam int AW     = ROW_W + EVT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [WORD_W-1:0] sample_in = '0;
  logic [WORD_W-1:0] stamp_in = '0;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic [AW-1:0]     wr_addr;
  logic              mem_wrapped;
  logic [CNT_W-1:0]  sample_count;

  always #2.5 clk = ~clk;

  ts_rle_packer #(.WORD_W(WORD_W), .ROW_W(ROW_W), .EVT_W(EVT_W),
                  .FORCE_TICKS(FORCE), .CNT_W(CNT_W)) u_ts_rle_packer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample_in(sample_in),
    .stamp_in(stamp_in), .wr_en(wr_en), .wr_data(wr_data),
    .wr_addr(wr_addr), .mem_wrapped(mem_wrapped), .sample_count(sample_count)
  );

  typedef struct {
    logic [AW-1:0]     a;
    logic [WORD_W-1:0] d;
    bit                stamp;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int failures = 0;
  int obs_writes = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  bit              m_primed = 1'b0;
  logic [WORD_W-1:0] m_last = '0;
  int              m_fill = 0;
  int              m_gap = 0;
  logic [WORD_W-1:0] m_ts = 16'hFFF0;
  logic [AW-1:0]   m_addr = '0;
  bit              m_wrapped = 1'b0;
  int              m_scount = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [WORD_W-1:0] d, input bit stamp);
    exp_t e;
    e.a = m_addr; e.d = d; e.stamp = stamp;
    q.push_back(e);
    if (&m_addr) m_wrapped = 1'b1;
    m_addr = m_addr + AW'(1);
    if (!stamp) m_scount++;
  endtask

  task automatic do_tick(input logic [WORD_W-1:0] s);
    bit open;
    open = (m_fill == 0) && (!m_primed || s != m_last || m_gap >= FORCE - 1);
    if (open) begin
      push(m_ts, 1'b1);
      push(s, 1'b0);
      m_fill = 1; m_gap = 0; m_primed = 1'b1; m_last = s;
    end else if (m_fill != 0) begin
      push(s, 1'b0);
      m_fill = (m_fill == 6) ? 0 : m_fill + 1;
      m_gap++; m_last = s;
    end else if (m_gap < FORCE) begin
      m_gap++;
    end
    @(negedge clk);
    tick = 1'b1; sample_in = s; stamp_in = m_ts;
    @(negedge clk);
    tick = 1'b0;
    m_ts = m_ts + 1'b1;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expected words as the design writes them
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      obs_writes++;
      if (q.size() == 0) begin
        check(1'b0, "R4", "unexpected write", longint'(wr_data), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.stamp) check(wr_data == e.d, "R2", "timestamp word", longint'(wr_data), longint'(e.d));
        else         check(wr_data == e.d, "R3", "sample word", longint'(wr_data), longint'(e.d));
        check(wr_addr == e.a, "R7", "word address", longint'(wr_addr), longint'(e.a));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w0;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wr_en == 1'b0, "R1", "wr_en after reset", longint'(wr_en), 0);
    check(wr_addr == '0, "R1", "wr_addr after reset", longint'(wr_addr), 0);
    check(sample_count == '0, "R1", "count after reset", longint'(sample_count), 0);
    check(mem_wrapped == 1'b0, "R1", "wrap after reset", longint'(mem_wrapped), 0);

    // R2: the first tick opens even with an all-zero sample; R3 repeats are stored
    for (int i = 0; i < 7; i++) do_tick(16'h0000);
    drain();
    check(obs_writes == 8, "R3", "cluster length", obs_writes, 8);
    check(sample_count == CNT_W'(m_scount), "R9", "count after first cluster", longint'(sample_count), m_scount);

    // R4: quiet ticks with unchanged value
    w0 = obs_writes; c0 = int'(sample_count);
    for (int i = 0; i < 10; i++) do_tick(16'h0000);
    drain();
    check(obs_writes == w0, "R4", "writes on quiet ticks", obs_writes - w0, 0);
    check(int'(sample_count) == c0, "R4", "count on quiet ticks", longint'(sample_count), c0);

    // R5: changes while filling stay in the cluster
    w0 = obs_writes;
    do_tick(16'h1234);
    for (int i = 0; i < 6; i++) do_tick(16'h1000 + 16'(i));
    do_tick(16'h1005);
    drain();
    check(obs_writes - w0 == 8, "R5", "one cluster for in-fill changes", obs_writes - w0, 8);
    w0 = obs_writes;
    do_tick(16'h1006);
    for (int i = 0; i < 6; i++) do_tick(16'h1006);
    drain();
    check(obs_writes - w0 == 8, "R5", "new cluster after fill", obs_writes - w0, 8);

    // R6: forced cluster with constant input
    w0 = obs_writes;
    for (int i = 0; i < 45; i++) do_tick(16'h1006);
    drain();
    check(obs_writes - w0 == 8, "R6", "forced cluster words", obs_writes - w0, 8);
    check(sample_count == CNT_W'(m_scount), "R9", "count after forced", longint'(sample_count), m_scount);

    // R7/R8: run across row boundaries and through the wrap
    for (int c = 0; c < 300; c++) begin
      do_tick(16'hA000 ^ 16'(c));
      for (int i = 0; i < 6; i++) do_tick(16'(c * 7 + i));
      drain();
      check(mem_wrapped == m_wrapped, "R8", "wrap flag", longint'(mem_wrapped), longint'(m_wrapped));
    end
    check(wr_addr == m_addr, "R8", "address after wrap", longint'(wr_addr), longint'(m_addr));
    check(sample_count == CNT_W'(m_scount), "R9", "final count", longint'(sample_count), m_scount);
    // R10: every expected word appeared exactly once
    check(q.size() == 0, "R10", "pending expected words", q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule